// File: doc/BRIEF.md
# SIMD Interleave and Widen Unit

This block rearranges a 64-bit SIMD register. It can merge two operands by interleaving their elements, or it can widen the elements of one operand to twice their size with zero or sign extension. It works on bytes, halfwords or words. The source elements always come from one 32-bit half of each operand, and a select input picks the lower or the upper half.

Each result comes with a 32-bit status word. For every lane of the result, the status word holds a negative flag and a zero flag. The flags are placed according to the result's own lane width. A single-cycle issue strobe starts an operation. The registered result, its status word and a one-cycle valid pulse appear on the next clock edge. The outputs then hold until the next issue.

Top module: `simd_unpack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o`, `result_o` and `flags_o` all become zero.
- R2: With `half_sel_i`=0 the source elements are bits [31:0] of each operand. With `half_sel_i`=1 they are bits [63:32].
- R3: With `mode_i`=0 (interleave) and `size_i`=0 (byte), selected byte k of A goes to result byte 2k and selected byte k of B goes to result byte 2k+1, for k from 0 to 3.
- R4: Interleave with `size_i`=1 (halfword) orders the result, from the low end, as A0, B0, A1, B1. Interleave with `size_i`=2 (word) puts the selected A word in bits [31:0] and the selected B word in bits [63:32].
- R5: With `mode_i`=1 (zero extend) or 2 (sign extend), operand A's selected bytes become four 16-bit lanes, its selected halfwords become two 32-bit lanes, or its selected word becomes one 64-bit value. Operand B is ignored.
- R6: The flag layout follows the result lane width W, which is the element size for interleave and twice the element size for widening. Lane i puts N at bit (W/2)*i + W/2 - 1 and Z one bit below it. So 8-bit lanes use bits 4i+3 and 4i+2, and a 64-bit result uses bits 31 and 30.
- R7: N equals the top bit of the result lane. Z is set exactly when the whole lane is zero. Every other status bit is zero.
- R8: `valid_o` is high for exactly the cycle after each cycle in which `issue_i` was high at the clock edge.
- R9: Without an issue, `result_o` and `flags_o` keep their values, whatever the other inputs do.
- R10: The reserved `size_i` code 3 acts as word. The reserved `mode_i` code 3 acts as zero extend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Start an operation this cycle |
| half_sel_i | input | 1 | 0 = lower 32 bits, 1 = upper 32 bits |
| size_i | input | 2 | Element size: 0 byte, 1 halfword, 2 word |
| mode_i | input | 2 | 0 interleave, 1 zero extend, 2 sign extend |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B (interleave only) |
| valid_o | output | 1 | Result-valid pulse |
| result_o | output | 64 | Registered result |
| flags_o | output | 32 | Per-lane N/Z status word |

## Verification
The embedded properties check on every cycle:
- the timing of the valid pulse after each issue;
- that the outputs hold between issues;
- that the status bits outside any N/Z slot stay zero;
- that N and Z agree with the result whenever the result is a single 64-bit lane.

Only the bench's scenarios can show the rest:
- that the correct bytes move to the correct positions for each size, half and mode;
- that sign extension happens at the element boundary;
- that the reserved encodings fall back as specified;
- that the per-lane flags land at the layout for the right width.

// File: rtl/simd_unpack_pkg.sv
package simd_unpack_pkg;

    localparam int DW      = 64;
    localparam int HALF_W  = DW / 2;
    localparam int FW      = DW / 2;
    localparam int N_WIDTH = 4;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_RSVD = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        UMODE_ILV  = 2'd0,
        UMODE_ZEXT = 2'd1,
        UMODE_SEXT = 2'd2,
        UMODE_RSVD = 2'd3
    } umode_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [FW-1:0] flags;
    } unpack_out_t;

    function automatic esz_e norm_size(input esz_e s);
        return (s == ESZ_RSVD) ? ESZ_WORD : s;
    endfunction

    function automatic lane_e lane_of(input esz_e s, input umode_e m);
        esz_e ns;
        ns = norm_size(s);
        if (m == UMODE_ILV) begin
            case (ns)
                ESZ_BYTE: return LANE_8;
                ESZ_HALF: return LANE_16;
                default:  return LANE_32;
            endcase
        end else begin
            case (ns)
                ESZ_BYTE: return LANE_16;
                ESZ_HALF: return LANE_32;
                default:  return LANE_64;
            endcase
        end
    endfunction

endpackage

// File: rtl/unpack_datapath.sv
module unpack_datapath
    import simd_unpack_pkg::*;
(
    input  logic          half_sel,
    input  esz_e          size,
    input  umode_e        mode,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] result,
    output lane_e         lane
);
    localparam int NB = HALF_W / 8;
    localparam int NH = HALF_W / 16;

    logic [HALF_W-1:0] sa, sb;
    logic [DW-1:0] ilv_b, ilv_h, ilv_w;
    logic [DW-1:0] wid_b, wid_h, wid_w;
    logic          sext;

    assign sa   = half_sel ? opa[DW-1:HALF_W] : opa[HALF_W-1:0];
    assign sb   = half_sel ? opb[DW-1:HALF_W] : opb[HALF_W-1:0];
    assign sext = (mode == UMODE_SEXT);

    // byte-granular interleave and byte-to-halfword widening
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign ilv_b[16*k +: 8]     = sa[8*k +: 8];
        assign ilv_b[16*k + 8 +: 8] = sb[8*k +: 8];
        assign wid_b[16*k +: 16]    = {{8{sext & sa[8*k+7]}}, sa[8*k +: 8]};
    end

    // halfword interleave and halfword-to-word widening
    for (genvar k = 0; k < NH; k++) begin : g_half
        assign ilv_h[32*k +: 16]      = sa[16*k +: 16];
        assign ilv_h[32*k + 16 +: 16] = sb[16*k +: 16];
        assign wid_h[32*k +: 32]      = {{16{sext & sa[16*k+15]}}, sa[16*k +: 16]};
    end

    assign ilv_w = {sb, sa};
    assign wid_w = {{HALF_W{sext & sa[HALF_W-1]}}, sa};

    always_comb begin
        lane = lane_of(size, mode);
        case (lane)
            LANE_8:  result = ilv_b;
            LANE_16: result = (mode == UMODE_ILV) ? ilv_h : wid_b;
            LANE_32: result = (mode == UMODE_ILV) ? ilv_w : wid_h;
            default: result = wid_w;
        endcase
    end

endmodule

// File: rtl/unpack_flags.sv
module unpack_flags
    import simd_unpack_pkg::*;
(
    input  logic [DW-1:0] data,
    input  lane_e         lane,
    output logic [FW-1:0] flags
);
    logic [N_WIDTH-1:0][FW-1:0] cand;

    for (genvar g = 0; g < N_WIDTH; g++) begin : g_width
        localparam int LW   = 8 << g;
        localparam int NL   = DW / LW;
        localparam int SLOT = LW / 2;
        logic [FW-1:0] v;
        always_comb begin
            v = '0;
            for (int i = 0; i < NL; i++) begin
                v[SLOT*i + SLOT - 1] = data[LW*i + LW - 1];
                v[SLOT*i + SLOT - 2] = ~|data[LW*i +: LW];
            end
        end
        assign cand[g] = v;
    end

    assign flags = cand[lane];

endmodule

// File: rtl/simd_unpack_unit.sv
module simd_unpack_unit
    import simd_unpack_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_i,
    input  logic          half_sel_i,
    input  logic [1:0]    size_i,
    input  logic [1:0]    mode_i,
    input  logic [63:0]   opa_i,
    input  logic [63:0]   opb_i,
    output logic          valid_o,
    output logic [63:0]   result_o,
    output logic [31:0]   flags_o
);
    unpack_out_t   nxt, cur;
    lane_e         lane;
    logic          valid_q;

    unpack_datapath u_dp (
        .half_sel (half_sel_i),
        .size     (esz_e'(size_i)),
        .mode     (umode_e'(mode_i)),
        .opa      (opa_i),
        .opb      (opb_i),
        .result   (nxt.data),
        .lane     (lane)
    );

    unpack_flags u_flags (
        .data  (nxt.data),
        .lane  (lane),
        .flags (nxt.flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur     <= '0;
        end else begin
            valid_q <= issue_i;
            if (issue_i) cur <= nxt;
        end
    end

    assign valid_o  = valid_q;
    assign result_o = cur.data;
    assign flags_o  = cur.flags;

    a_r8_valid_after_issue: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> valid_o);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> !valid_o);

    a_r9_hold_between_issues: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> ($stable(result_o) && $stable(flags_o)));

    a_r7_unused_flag_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (flags_o & 32'h3333_3333) == 32'h0);

    a_r6_wide_lane_flags: assert property (@(posedge clk) disable iff (rst)
        (issue_i && mode_i != 2'd0 && size_i[1])
        |=> (flags_o[31] == result_o[63] && flags_o[30] == (result_o == 64'h0)
             && flags_o[29:0] == 30'h0));

endmodule

// File: tb/simd_unpack_unit_tb.sv
module simd_unpack_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i;
    logic        half_sel_i;
    logic [1:0]  size_i;
    logic [1:0]  mode_i;
    logic [63:0] opa_i, opb_i;
    logic        valid_o;
    logic [63:0] result_o;
    logic [31:0] flags_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    simd_unpack_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue_i),
        .half_sel_i (half_sel_i),
        .size_i     (size_i),
        .mode_i     (mode_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .valid_o    (valid_o),
        .result_o   (result_o),
        .flags_o    (flags_o)
    );

    typedef struct packed {
        logic        hs;
        logic [1:0]  sz;
        logic [1:0]  md;
        logic [63:0] a;
        logic [63:0] b;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
        '{1'b1, 2'd0, 2'd0, 64'h8000_7F00_1234_5678, 64'h00FF_0080_AAAA_5555},
        '{1'b0, 2'd1, 2'd0, 64'h1111_2222_8000_0000, 64'h0000_FFFF_0001_7FFF},
        '{1'b1, 2'd2, 2'd0, 64'hDEAD_BEEF_0000_0000, 64'h0000_0000_CAFE_F00D},
        '{1'b0, 2'd0, 2'd1, 64'h0000_0000_80FF_007F, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 2'd0, 2'd2, 64'h80FF_007F_0000_0000, 64'h1234_5678_9ABC_DEF0},
        '{1'b0, 2'd1, 2'd2, 64'h0000_0000_8001_7FFF, 64'h0},
        '{1'b1, 2'd1, 2'd1, 64'hFFFF_0000_1234_5678, 64'h0},
        '{1'b0, 2'd2, 2'd2, 64'h0000_0000_8000_0001, 64'h0},
        '{1'b1, 2'd2, 2'd1, 64'hF000_0000_0000_0000, 64'h5},
        '{1'b0, 2'd3, 2'd0, 64'h0000_0000_0000_0000, 64'h7777_6666_8888_9999},
        '{1'b1, 2'd0, 2'd3, 64'h8081_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    // reference model written from the requirements
    task automatic ref_model(input logic hs, input logic [1:0] sz, input logic [1:0] md,
                             input logic [63:0] a, input logic [63:0] b,
                             output logic [63:0] r, output logic [31:0] f);
        logic [31:0] sa, sb;
        int ew, n, lw, slot;
        logic zero;
        sa = hs ? a[63:32] : a[31:0];
        sb = hs ? b[63:32] : b[31:0];
        ew = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        n  = 32 / ew;
        r  = '0;
        if (md == 2'd0) begin
            lw = ew;
            for (int k = 0; k < n; k++)
                for (int j = 0; j < ew; j++) begin
                    r[2*k*ew + j]     = sa[k*ew + j];
                    r[(2*k+1)*ew + j] = sb[k*ew + j];
                end
        end else begin
            lw = 2 * ew;
            for (int k = 0; k < n; k++)
                for (int j = 0; j < lw; j++)
                    r[k*lw + j] = (j < ew) ? sa[k*ew + j]
                                           : ((md == 2'd2) ? sa[k*ew + ew - 1] : 1'b0);
        end
        f = '0;
        slot = lw / 2;
        for (int i = 0; i < 64 / lw; i++) begin
            zero = 1'b1;
            for (int j = 0; j < lw; j++) if (r[i*lw + j]) zero = 1'b0;
            f[slot*i + slot - 1] = r[i*lw + lw - 1];
            f[slot*i + slot - 2] = zero;
        end
    endtask

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue_op(input logic hs, input logic [1:0] sz, input logic [1:0] md,
                            input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        issue_i = 1'b1; half_sel_i = hs; size_i = sz; mode_i = md; opa_i = a; opb_i = b;
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] er, hr;
        logic [31:0] ef, hf;
        rst = 1'b1; issue_i = 1'b0; half_sel_i = 1'b0; size_i = '0; mode_i = '0;
        opa_i = '0; opb_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk64("R1 valid", {63'h0, valid_o}, 64'h0);
        chk64("R1 result", result_o, 64'h0);
        chk64("R1 flags", {32'h0, flags_o}, 64'h0);
        rst = 1'b0;

        // table walk: R2 R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            issue_op(VECS[v].hs, VECS[v].sz, VECS[v].md, VECS[v].a, VECS[v].b);
            ref_model(VECS[v].hs, VECS[v].sz, VECS[v].md, VECS[v].a, VECS[v].b, er, ef);
            chk64("R8 valid pulse", {63'h0, valid_o}, 64'h1);
            chk64("R2/R3/R4/R5/R10 result", result_o, er);
            chk64("R6/R7 flags", {32'h0, flags_o}, {32'h0, ef});
        end

        // R3 R6 byte interleave, hand-computed
        issue_op(1'b0, 2'd0, 2'd0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9900);
        chk64("R3 byte interleave", result_o, 64'hBB44_AA33_9922_0011);
        chk64("R6 byte lane flags", {32'h0, flags_o}, 64'h8080_8040);

        // R5 sign extend, word, upper half
        issue_op(1'b1, 2'd2, 2'd2, 64'h8000_0000_1234_5678, 64'h0);
        chk64("R5 sign extend word", result_o, 64'hFFFF_FFFF_8000_0000);
        chk64("R7 64-bit N flag", {32'h0, flags_o}, 64'h8000_0000);

        // R7 zero result in 64-bit lane; R5 operand B ignored
        issue_op(1'b0, 2'd2, 2'd1, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        chk64("R5 zero extend ignores B", result_o, 64'h0);
        chk64("R7 64-bit Z flag", {32'h0, flags_o}, 64'h4000_0000);

        // R8 single pulse, R9 hold under changing inputs
        hr = result_o; hf = flags_o;
        @(negedge clk);
        opa_i = 64'hAAAA_AAAA_AAAA_AAAA; opb_i = 64'h5555_5555_5555_5555; mode_i = 2'd0;
        chk64("R8 valid drops", {63'h0, valid_o}, 64'h0);
        @(negedge clk);
        chk64("R9 result held", result_o, hr);
        chk64("R9 flags held", {32'h0, flags_o}, {32'h0, hf});

        // R8 back-to-back issues keep valid high
        @(negedge clk);
        issue_i = 1'b1; half_sel_i = 1'b0; size_i = 2'd1; mode_i = 2'd1;
        opa_i = 64'h0000_0000_FFFF_0001;
        @(negedge clk);
        chk64("R8 first of pair", {63'h0, valid_o}, 64'h1);
        chk64("R5 zero extend half", result_o, 64'h0000_FFFF_0000_0001);
        half_sel_i = 1'b1;
        opa_i = 64'h0001_8000_0000_0000;
        mode_i = 2'd2;
        @(negedge clk);
        issue_i = 1'b0;
        chk64("R8 second of pair", {63'h0, valid_o}, 64'h1);
        chk64("R2 upper half sign extend", result_o, 64'h0000_0001_FFFF_8000);
        chk64("R6 32-bit lane flags", {32'h0, flags_o}, 64'h0000_8000);

        // R1 reset clears after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk64("R1 result after reset", result_o, 64'h0);
        chk64("R1 flags after reset", {32'h0, flags_o}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule